// File: doc/BRIEF.md
# Multi-mode field input debouncer

This block cleans up slow digital field inputs before they reach control logic. It has eight channels. Each raw input bit passes through its own filter, and the filter settings can differ from channel to channel. Every channel has a 2-bit delay code, which gives a hold time in millisecond ticks, and a 2-bit mode code, which picks the filter algorithm. A pulse that lasts one clock on the `tick_ms` input marks each elapsed millisecond. All counting advances on that pulse.

Three algorithms are available. The trailing-edge filter passes a new level only after it has held steady for the whole delay. The low-pass filter counts up while the input disagrees with the output and counts down while the two agree, so time spent at the new level before a glitch is not lost. The leading-edge filter passes a change at once and then locks the output for the delay. When the delay code is zero, the channel is a single register stage whatever its mode.

Top module: `field_debounce_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `filt_out` is 0 and every channel counter is cleared. This holds even when `raw_in` is all ones.
- R2: In each channel's delay field, code 00 means zero delay, 01 means 10 ticks, 10 means 30 ticks and 11 means 100 ticks. A channel counter never holds more than 100.
- R3: With delay code 00, a channel's output equals its raw input one clock later, in every mode. No tick is needed.
- R4: Mode 00 (trailing edge): the output takes the input on the clock edge of the D-th tick in a row on which the input differs from the output. Any cycle on which the input matches the output clears the progress.
- R5: Mode 01 (low-pass): each tick on which the input differs from the output adds one to the counter. Each tick on which they match subtracts one. The output takes the input on the tick that would bring the count to D, so progress made before a glitch is kept.
- R6: In mode 01 the down-count stops at zero, and the counter returns to zero when the output switches.
- R7: Mode 10 or 11 (leading edge): while the counter is zero, an input that differs from the output is copied to the output on the next clock edge, with or without a tick, and the counter is loaded with D.
- R8: In leading-edge mode the output is frozen while the counter is non-zero. The counter falls by one on each tick whatever the input does. After it reaches zero, an input that still differs is passed on the next clock edge.
- R9: Outside bypass, counters move only on clock cycles where `tick_ms` is high. Without ticks, the trailing-edge and low-pass outputs never change.
- R10: Channel n takes its mode from `mode_cfg[2n+1:2n]` and its delay from `dly_cfg[2n+1:2n]`. A channel's input and settings have no effect on any other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick_ms | input | 1 | One-cycle enable per millisecond |
| raw_in | input | 8 | Unfiltered channel inputs |
| mode_cfg | input | 16 | Two mode bits per channel, channel 0 lowest |
| dly_cfg | input | 16 | Two delay bits per channel, channel 0 lowest |
| filt_out | output | 8 | Filtered channel outputs |

## Verification
The bench applies pulses slightly shorter and slightly longer than each delay and measures the exact edge on which each output rises and falls. An off-by-one in the limit compare shows up as a shifted edge, and a leading-edge filter that releases too early shows up as a shortened pulse.

A high-low-high pattern runs on a trailing-edge channel and a low-pass channel side by side. A low-pass filter that clears its counter instead of decrementing would wait the full delay, like the trailing-edge channel does. Long idle stretches after a short pulse catch a down-counter that wraps below zero, since a wrapped counter lets the next edge through at once. Switching the tick off shows whether any counting leaks through without ticks, and whether the leading-edge pass wrongly waits for a tick.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  typedef enum logic [1:0] {
    DLY_BYPASS = 2'b00,
    DLY_SHORT  = 2'b01,
    DLY_MID    = 2'b10,
    DLY_LONG   = 2'b11
  } dly_code_e;

  // Delay code to tick count.
  function automatic int unsigned dly_ticks(input logic [1:0] code,
                                            input int unsigned t_short,
                                            input int unsigned t_mid,
                                            input int unsigned t_long);
    case (code)
      DLY_SHORT: return t_short;
      DLY_MID:   return t_mid;
      DLY_LONG:  return t_long;
      default:   return 0;
    endcase
  endfunction

  function automatic logic is_leading(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic is_lowpass(input logic [1:0] mode);
    return mode == 2'b01;
  endfunction

  // True when one more step would reach the limit.
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/dbnc_delay_map.sv
module dbnc_delay_map
  import dbnc_pkg::*;
#(
  parameter int unsigned CW      = 7,
  parameter int unsigned T_SHORT = 10,
  parameter int unsigned T_MID   = 30,
  parameter int unsigned T_LONG  = 100
) (
  input  logic [1:0]    code,
  output logic [CW-1:0] lim
);

  always_comb begin
    lim = CW'(dly_ticks(code, T_SHORT, T_MID, T_LONG));
  end

endmodule

// File: rtl/dbnc_channel.sv
module dbnc_channel
  import dbnc_pkg::*;
#(
  parameter int unsigned CW   = 7,
  parameter int unsigned DMAX = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          din,
  input  logic [1:0]    mode,
  input  logic [1:0]    dly_code,
  input  logic [CW-1:0] lim,
  output logic          dout
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  // Named events for the assertions
  logic bypass, leading, lowpass, differ, reached, cnt_zero;

  assign bypass   = (dly_code == DLY_BYPASS);
  assign leading  = is_leading(mode);
  assign lowpass  = is_lowpass(mode);
  assign differ   = (din != out_q);
  assign cnt_zero = (cnt_q == '0);
  assign reached  = limit_hit(32'(cnt_q), 32'(lim));

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (bypass) begin
      out_d = din;
      cnt_d = '0;
    end else if (leading) begin
      if (cnt_zero) begin
        if (differ) begin
          out_d = din;
          cnt_d = lim;
        end
      end else if (tick) begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (lowpass) begin
      if (differ) begin
        if (tick) begin
          if (reached) begin
            out_d = din;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end else if (tick && !cnt_zero) begin
        cnt_d = cnt_q - 1'b1;
      end
    end else begin
      if (!differ) begin
        cnt_d = '0;
      end else if (tick) begin
        if (reached) begin
          out_d = din;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (dout == $past(din)));                                     // R3

  AST_SLOW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !leading && !tick) |=> $stable(dout));                    // R9

  AST_LEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && leading && !cnt_zero) |=> $stable(dout));                 // R8

  AST_LOWPASS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && lowpass && !differ && cnt_zero) |=> (cnt_q == '0));       // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DMAX));                                                  // R2

endmodule

// File: rtl/field_debounce_bank.sv
module field_debounce_bank
  import dbnc_pkg::*;
#(
  parameter int unsigned NCH     = 8,
  parameter int unsigned T_SHORT = 10,
  parameter int unsigned T_MID   = 30,
  parameter int unsigned T_LONG  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic [NCH-1:0]   raw_in,
  input  logic [2*NCH-1:0] mode_cfg,
  input  logic [2*NCH-1:0] dly_cfg,
  output logic [NCH-1:0]   filt_out
);

  localparam int unsigned CW = $clog2(T_LONG + 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [1:0]    ch_mode;
    logic [1:0]    ch_dly;
    logic [CW-1:0] ch_lim;

    assign ch_mode = mode_cfg[2*g +: 2];
    assign ch_dly  = dly_cfg[2*g +: 2];

    dbnc_delay_map #(
      .CW(CW), .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)
    ) map_i (
      .code (ch_dly),
      .lim  (ch_lim)
    );

    dbnc_channel #(
      .CW(CW), .DMAX(T_LONG)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .din      (raw_in[g]),
      .mode     (ch_mode),
      .dly_code (ch_dly),
      .lim      (ch_lim),
      .dout     (filt_out[g])
    );
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (filt_out == '0));                                          // R1

endmodule

// File: tb/field_debounce_bank_tb_top.sv
module field_debounce_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic [7:0]  raw_in = '0;
  logic [15:0] mode_cfg = '0;
  logic [15:0] dly_cfg = '0;
  logic [7:0]  filt_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  field_debounce_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_in(raw_in),
    .mode_cfg(mode_cfg), .dly_cfg(dly_cfg), .filt_out(filt_out)
  );

  // Row fields: [30:28] channel, [27:26] mode, [25:24] delay code,
  // [23:16] pulse width, [15:8] first high cycle, [7:0] cycles high.
  localparam logic [30:0] ROWS [10] = '{
    {3'd0, 2'b00, 2'b01, 8'd15,  8'd10,  8'd15},
    {3'd1, 2'b00, 2'b01, 8'd9,   8'd0,   8'd0},
    {3'd2, 2'b01, 2'b10, 8'd30,  8'd30,  8'd30},
    {3'd3, 2'b01, 2'b10, 8'd29,  8'd0,   8'd0},
    {3'd4, 2'b10, 2'b01, 8'd3,   8'd1,   8'd11},
    {3'd5, 2'b11, 2'b01, 8'd20,  8'd1,   8'd20},
    {3'd6, 2'b00, 2'b00, 8'd4,   8'd1,   8'd4},
    {3'd7, 2'b01, 2'b00, 8'd1,   8'd1,   8'd1},
    {3'd7, 2'b00, 2'b11, 8'd100, 8'd100, 8'd100},
    {3'd6, 2'b11, 2'b10, 8'd5,   8'd1,   8'd31}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    raw_in = '0;
    step(3);
    rst_n = 1'b1;
  endtask

  function automatic int ticks_of(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b01:   return 10;
      2'b10:   return 30;
      default: return 100;
    endcase
  endfunction

  task automatic set_ch(input int ch, input logic [1:0] m, input logic [1:0] d);
    mode_cfg[2*ch +: 2] = m;
    dly_cfg[2*ch +: 2]  = d;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset holds outputs low with all inputs high
    rst_n = 1'b0; raw_in = 8'hFF; mode_cfg = '0; dly_cfg = '0;
    step(3);
    check("R1 outputs in reset", int'(filt_out), 0);
    rst_n = 1'b1;
    step(1);
    check("R3 bypass follows", int'(filt_out), 8'hFF);
    raw_in = 8'h5A;
    step(1);
    check("R3 bypass pattern", int'(filt_out), 8'h5A);

    // Table walk
    tick_ms = 1'b1;
    for (int r = 0; r < 10; r++) begin
      logic [30:0] v;
      int ch, w, d, first, high, other;
      logic [1:0] m, dc;
      string req;
      v  = ROWS[r];
      ch = int'(v[30:28]);
      m  = v[27:26];
      dc = v[25:24];
      w  = int'(v[23:16]);
      d  = ticks_of(dc);
      mode_cfg = '0;
      dly_cfg  = 16'hFFFF;
      set_ch(ch, m, dc);
      do_reset();
      if (dc == 2'b00)  req = "R3";
      else if (m[1])    req = "R7";
      else if (m == 2'b01) req = "R5";
      else              req = "R4";
      first = 0; high = 0; other = 0;
      raw_in[ch] = 1'b1;
      for (int c = 1; c <= w + d + 12; c++) begin
        step(1);
        if (filt_out[ch]) begin
          high++;
          if (first == 0) first = c;
        end
        if ((filt_out & ~(8'd1 << ch)) != 8'd0) other++;
        if (c == w) raw_in[ch] = 1'b0;
      end
      check({"R2 first edge / ", req}, first, int'(v[15:8]));
      check({req, " high cycles"}, high, int'(v[7:0]));
      check("R10 other channels quiet", other, 0);
    end

    // R5 credit against R4 restart
    mode_cfg = '0; dly_cfg = 16'hFFFF;
    set_ch(0, 2'b00, 2'b01);
    set_ch(1, 2'b01, 2'b01);
    tick_ms = 1'b1;
    do_reset();
    raw_in[1:0] = 2'b11; step(6);
    raw_in[1:0] = 2'b00; step(3);
    raw_in[1:0] = 2'b11; step(6);
    check("R5 not yet after 6", int'(filt_out[1]), 0);
    step(1);
    check("R5 credited pass at 7", int'(filt_out[1]), 1);
    check("R4 no credit at 7", int'(filt_out[0]), 0);
    step(2);
    check("R4 still low at 9", int'(filt_out[0]), 0);
    step(1);
    check("R4 pass at 10", int'(filt_out[0]), 1);

    // R6 floor at zero and clear on update
    mode_cfg = '0; dly_cfg = 16'hFFFF;
    set_ch(2, 2'b01, 2'b01);
    do_reset();
    raw_in[2] = 1'b1; step(3);
    raw_in[2] = 1'b0; step(20);
    raw_in[2] = 1'b1; step(9);
    check("R6 full delay after idle", int'(filt_out[2]), 0);
    step(1);
    check("R6 pass at full delay", int'(filt_out[2]), 1);
    raw_in[2] = 1'b0; step(9);
    check("R6 counter cleared on update", int'(filt_out[2]), 1);
    step(1);
    check("R6 release at full delay", int'(filt_out[2]), 0);

    // R9 tick gating, R7/R8 leading edge without ticks
    mode_cfg = '0; dly_cfg = 16'hFFFF;
    set_ch(3, 2'b00, 2'b01);
    set_ch(4, 2'b10, 2'b01);
    do_reset();
    tick_ms = 1'b0;
    raw_in[3] = 1'b1; raw_in[4] = 1'b1;
    step(1);
    check("R7 pass without tick", int'(filt_out[4]), 1);
    step(40);
    check("R9 no count without tick", int'(filt_out[3]), 0);
    raw_in[4] = 1'b0;
    step(40);
    check("R8 hold with no ticks", int'(filt_out[4]), 1);
    tick_ms = 1'b1;
    step(10);
    check("R8 hold until expiry", int'(filt_out[4]), 1);
    check("R9 counts once ticking", int'(filt_out[3]), 1);
    step(1);
    check("R8 pass after expiry", int'(filt_out[4]), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule